// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a 40-bit nanosecond time of day for precision time protocol use. Every cycle of its reference clock is one tick, and on each tick the counter advances by a fixed 8 ns step. A 32-bit sign-magnitude trim word lets software speed the clock up or slow it down. Its 31-bit magnitude is added each tick into a 32-bit accumulator of fractional nanoseconds (units of 2^-32 ns). Whenever that accumulator carries out, the tick moves by one nanosecond more, or one less, than the nominal 8 ns, as the sign bit selects. For a wanted correction of p parts per billion, software writes (p << 26) / 1953125 as the magnitude.

Software reaches the block through a simple word-wide register port. Reading the fractional word takes a coherent snapshot of the whole time: the fraction, the low 32 nanosecond bits and the high 8 bits. The snapshot then stays frozen until the high word is read, so a three-word read cannot tear. To set the time, software writes the low word, which is only staged, and then the high word. The counter takes both words on the same edge, and the accumulator is cleared at that moment. A halt bit in the control word stops all counting. It is set out of reset.

Top module: `tod_rate_counter`

## Requirements
- R1: After reset the control word (address 0) reads 0x8000_0000 (halt set), the trim word (address 1) reads 0, the counter, accumulator and snapshot are zero, and the counter does not advance while halted.
- R2: While running with a trim magnitude (bits 30:0 of address 1) of zero, the counter advances by exactly 8 per tick, whatever the value of the trim sign bit 31.
- R3: Each running tick adds the trim magnitude into the 32-bit accumulator. When the accumulator carries out, that tick adds 9 if sign bit 31 is 0, or 7 if it is 1.
- R4: The counter is 40 bits wide and wraps modulo 2^40.
- R5: Setting bit 31 of the control word stops both the counter and the accumulator. Writing 0 to the control word resumes counting on the next tick.
- R6: A write to address 3 only stages the low word and leaves the running time untouched. A write to address 4 loads {wdata[7:0], staged low word} into the counter on that edge and clears the accumulator.
- R7: A read of address 2 captures the counter and accumulator into the snapshot on that edge. Read data appears on reg_rdata one cycle after the strobe: the fraction for address 2, snapshot bits 31:0 for address 3, and snapshot bits 39:32 for address 4.
- R8: Once captured, the snapshot is held and further reads of address 2 return the held fraction. A read of address 4 releases it, returns zero in bits 31:8, and lets the next read of address 2 capture fresh values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tod_ns | output | 40 | Live nanosecond count |

## Verification
The bench goes after the carry handling of the trim. A positive quarter-nanosecond trim must yield exactly 82 ns over ten ticks and a negative one 78 ns. A sign bit set with a zero magnitude must change nothing, and a design that decoded the sign alone would lose a nanosecond every tick. It loads a time 8 ns below the top of the range and checks that the count wraps to a small value, which a design with a wider or narrower counter would not do. It also checks that a second fractional read during the freeze returns the held value; a design that re-captured would return a newer fraction. Finally it writes the low word alone and expects the time unchanged, then loads the staged word with the high one, where a design that applied the low word at once would jump the clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
   typedef enum logic [2:0] {
      ADDR_CTRL = 3'd0,
      ADDR_TRIM = 3'd1,
      ADDR_FRAC = 3'd2,
      ADDR_LO   = 3'd3,
      ADDR_HI   = 3'd4
   } tod_addr_e;

   localparam int unsigned TOD_WORD_W = 32;

   typedef struct packed {
      logic        neg;
      logic [30:0] mag;
   } trim_t;
endpackage

// File: rtl/tod_rate_accum.sv
module tod_rate_accum #(
   parameter int unsigned FRAC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic [FRAC_W-2:0] mag,
   output logic [FRAC_W-1:0] acc_q,
   output logic              carry
);
   logic [FRAC_W:0] sum;

   always_comb begin
      sum   = {1'b0, acc_q} + {2'b00, mag};
      carry = en & sum[FRAC_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (en)  acc_q <= sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
   parameter int unsigned NS_W    = 40,
   parameter int unsigned STEP_NS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            carry,
   input  logic            neg,
   input  logic            load,
   input  logic [NS_W-1:0] load_val,
   output logic [NS_W-1:0] ns_q
);
   localparam logic [NS_W-1:0] STEP_NOM  = NS_W'(STEP_NS);
   localparam logic [NS_W-1:0] STEP_FAST = NS_W'(STEP_NS + 1);
   localparam logic [NS_W-1:0] STEP_SLOW = NS_W'(STEP_NS - 1);

   logic [NS_W-1:0] step;

   always_comb begin
      if (!carry)   step = STEP_NOM;
      else if (neg) step = STEP_SLOW;
      else          step = STEP_FAST;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    ns_q <= '0;
      else if (load) ns_q <= load_val;
      else if (en)   ns_q <= ns_q + step;
   end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
   parameter int unsigned NS_W   = 40,
   parameter int unsigned FRAC_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_req,
   input  logic              rel_req,
   input  logic [NS_W-1:0]   ns_in,
   input  logic [FRAC_W-1:0] frac_in,
   output logic              hold,
   output logic [NS_W-1:0]   snap_ns,
   output logic [FRAC_W-1:0] frac_view,
   output logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] hi_word
);
   localparam int unsigned HI_BITS = NS_W - DATA_W;

   logic [FRAC_W-1:0] snap_frac;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold      <= 1'b0;
         snap_ns   <= '0;
         snap_frac <= '0;
      end else if (cap_req && !hold) begin
         hold      <= 1'b1;
         snap_ns   <= ns_in;
         snap_frac <= frac_in;
      end else if (rel_req) begin
         hold      <= 1'b0;
      end
   end

   assign frac_view = hold ? snap_frac : frac_in;
   assign lo_word   = snap_ns[DATA_W-1:0];

   generate
      if (HI_BITS == DATA_W) begin : g_hi_full
         assign hi_word = snap_ns[NS_W-1:DATA_W];
      end else begin : g_hi_pad
         assign hi_word = {{(DATA_W-HI_BITS){1'b0}}, snap_ns[NS_W-1:DATA_W]};
      end
   endgenerate
endmodule

// File: rtl/tod_rate_counter.sv
module tod_rate_counter #(
   parameter int unsigned NS_W    = 40,
   parameter int unsigned FRAC_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned STEP_NS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NS_W-1:0]   tod_ns
);
   import tod_pkg::*;

   localparam int unsigned HI_BITS = NS_W - DATA_W;

   generate
      if (DATA_W != TOD_WORD_W) begin : g_bad_data_w
         $error("DATA_W must equal the package word width");
      end
      if (FRAC_W != DATA_W) begin : g_bad_frac_w
         $error("FRAC_W must equal DATA_W so the trim word fits");
      end
      if (NS_W <= DATA_W || HI_BITS > DATA_W) begin : g_bad_ns_w
         $error("NS_W must lie between DATA_W+1 and 2*DATA_W");
      end
      if (STEP_NS < 2) begin : g_bad_step
         $error("STEP_NS must be at least 2");
      end
   endgenerate

   logic              halt_q;
   trim_t             trim_q;
   logic [DATA_W-1:0] stage_lo;
   logic              load_hi;
   logic              tick_en;
   logic              carry;
   logic [FRAC_W-1:0] acc_q;
   logic [NS_W-1:0]   ns_q;
   logic              snap_hold;
   logic [NS_W-1:0]   snap_ns;
   logic [FRAC_W-1:0] frac_view;
   logic [DATA_W-1:0] lo_word;
   logic [DATA_W-1:0] hi_word;
   logic              rd_frac;
   logic              rd_hi;

   assign load_hi = reg_wr && (reg_addr == ADDR_HI);
   assign tick_en = !halt_q;
   assign rd_frac = reg_rd && (reg_addr == ADDR_FRAC);
   assign rd_hi   = reg_rd && (reg_addr == ADDR_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q   <= 1'b1;
         trim_q   <= '0;
         stage_lo <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_CTRL: halt_q   <= reg_wdata[DATA_W-1];
            ADDR_TRIM: trim_q   <= trim_t'(reg_wdata);
            ADDR_LO:   stage_lo <= reg_wdata;
            default:   ;
         endcase
      end
   end

   tod_rate_accum #(.FRAC_W(FRAC_W)) accum_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tick_en),
      .clr   (load_hi),
      .mag   (trim_q.mag),
      .acc_q (acc_q),
      .carry (carry)
   );

   tod_ns_counter #(.NS_W(NS_W), .STEP_NS(STEP_NS)) count_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (tick_en),
      .carry    (carry),
      .neg      (trim_q.neg),
      .load     (load_hi),
      .load_val ({reg_wdata[HI_BITS-1:0], stage_lo}),
      .ns_q     (ns_q)
   );

   tod_snapshot #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) snap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_req   (rd_frac),
      .rel_req   (rd_hi),
      .ns_in     (ns_q),
      .frac_in   (acc_q),
      .hold      (snap_hold),
      .snap_ns   (snap_ns),
      .frac_view (frac_view),
      .lo_word   (lo_word),
      .hi_word   (hi_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         case (reg_addr)
            ADDR_CTRL: reg_rdata <= {halt_q, {(DATA_W-1){1'b0}}};
            ADDR_TRIM: reg_rdata <= trim_q;
            ADDR_FRAC: reg_rdata <= frac_view;
            ADDR_LO:   reg_rdata <= lo_word;
            ADDR_HI:   reg_rdata <= hi_word;
            default:   reg_rdata <= '0;
         endcase
      end
   end

   assign tod_ns = ns_q;
endmodule

// File: rtl/tod_rate_counter_chk.sv
module tod_rate_counter_chk #(
   parameter int unsigned NS_W   = 40,
   parameter int unsigned FRAC_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NS_W-1:0]   tod_ns,
   input logic              halt,
   input logic              load,
   input logic [30:0]       trim_mag,
   input logic [FRAC_W-1:0] acc,
   input logic              hold,
   input logic [NS_W-1:0]   snap_ns
);
   localparam int unsigned HI_BITS = NS_W - DATA_W;

   assert_nominal_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && !load && trim_mag == '0) |=> (tod_ns - $past(tod_ns)) == NS_W'(8));

   assert_trim_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && !load) |=> ((tod_ns - $past(tod_ns)) == NS_W'(7) ||
                            (tod_ns - $past(tod_ns)) == NS_W'(8) ||
                            (tod_ns - $past(tod_ns)) == NS_W'(9)));

   assert_halt_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !load) |=> ($stable(tod_ns) && $stable(acc)));

   assert_load_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> acc == '0);

   assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !(reg_rd && reg_addr == 3'd4)) |=> ($stable(snap_ns) && hold));

   assert_hi_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd4) |=> reg_rdata[DATA_W-1:HI_BITS] == '0);
endmodule

bind tod_rate_counter tod_rate_counter_chk #(
   .NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .tod_ns    (tod_ns),
   .halt      (halt_q),
   .load      (load_hi),
   .trim_mag  (trim_q.mag),
   .acc       (acc_q),
   .hold      (snap_hold),
   .snap_ns   (snap_ns)
);

// File: tb/tod_rate_counter_tb.sv
module tod_rate_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic [39:0] tod_ns;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tod_rate_counter dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tod_ns(tod_ns)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [39:0] t);
      wr(3'd3, t[31:0]);
      wr(3'd4, {24'd0, t[39:32]});
   endtask

   // snapshot: frac read (capture), lo read, hi read (release)
   task automatic snap(output logic [39:0] ns, output logic [31:0] fr, output logic [31:0] hi);
      logic [31:0] lo;
      rd(3'd2, fr);
      rd(3'd3, lo);
      rd(3'd4, hi);
      ns = {hi[7:0], lo};
   endtask

   task automatic model(input logic [39:0] l, input logic [31:0] t, input int n,
                        output logic [39:0] ns, output logic [31:0] fr);
      logic [32:0] s;
      ns = l; fr = 32'd0;
      for (int k = 0; k < n; k++) begin
         s  = {1'b0, fr} + {2'b00, t[30:0]};
         fr = s[31:0];
         ns = ns + 40'd8;
         if (s[32]) ns = t[31] ? ns - 40'd1 : ns + 40'd1;
      end
   endtask

   task automatic run_case(input string tag, input logic [31:0] trim,
                           input logic [39:0] l, input int m);
      logic [39:0] ns, ens;
      logic [31:0] fr, efr, hi;
      wr(3'd0, 32'd0);
      wr(3'd1, trim);
      load(l);
      idle(m);
      snap(ns, fr, hi);
      model(l, trim, m, ens, efr);
      check({tag, " ns"}, ns, ens);
      check({tag, " frac"}, fr, efr);
      check("R8 hi reserved", hi[31:8], 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic [39:0] ns;
      logic [31:0] fr, hi;
      rd(3'd0, d); check("R1 ctrl reset", d, 32'h8000_0000);
      rd(3'd1, d); check("R1 trim reset", d, 0);
      snap(ns, fr, hi);
      check("R1 time reset", ns, 0);
      check("R1 frac reset", fr, 0);
      idle(10);
      snap(ns, fr, hi);
      check("R1 halted no count", ns, 0);
   endtask

   task automatic t_freeze();
      logic [31:0] f1, f2, f3, lo, hi;
      logic [39:0] l, e5, e19;
      logic [31:0] ef5, ef19;
      l = 40'h03_1000_0000;
      wr(3'd0, 32'd0);
      wr(3'd1, 32'h4000_0000);
      load(l);
      idle(5);
      rd(3'd2, f1);
      idle(10);
      rd(3'd3, lo);
      rd(3'd2, f2);
      rd(3'd4, hi);
      rd(3'd2, f3);
      model(l, 32'h4000_0000, 5, e5, ef5);
      model(l, 32'h4000_0000, 19, e19, ef19);
      check("R7 capture frac", f1, ef5);
      check("R8 frozen lo", lo, e5[31:0]);
      check("R8 held frac reread", f2, ef5);
      check("R8 frozen hi", hi, {24'd0, e5[39:32]});
      check("R8 fresh capture after release", f3, ef19);
      rd(3'd3, lo);
      rd(3'd4, hi);
      check("R8 fresh lo", lo, e19[31:0]);
   endtask

   task automatic t_halt();
      logic [39:0] ns, l;
      logic [31:0] fr, hi;
      l = 40'h00_0000_1000;
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h8000_0000);
      load(l);
      idle(20);
      snap(ns, fr, hi);
      check("R5 halted holds time", ns, l);
      wr(3'd0, 32'd0);
      idle(5);
      snap(ns, fr, hi);
      check("R5 resume counts", ns, l + 40'd40);
   endtask

   task automatic t_stage();
      logic [39:0] ns, l;
      logic [31:0] fr, hi;
      l = 40'h22_0000_0100;
      wr(3'd0, 32'd0);
      wr(3'd1, 32'd0);
      load(l);
      idle(2);
      wr(3'd3, 32'h0000_DEAD);
      idle(2);
      snap(ns, fr, hi);
      check("R6 low write only stages", ns, l + 40'd40);
      wr(3'd4, 32'h0000_0001);
      snap(ns, fr, hi);
      check("R6 high write loads staged low", ns, 40'h01_0000_DEAD);
      check("R6 load clears accumulator", fr, 0);
   endtask

   initial begin
      logic [31:0] ppb_trim;
      ppb_trim = 32'((64'd1000000 << 26) / 64'd1953125);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      run_case("R2 nominal", 32'h0000_0000, 40'h12_3456_7000, 10);
      run_case("R2 sign only", 32'h8000_0000, 40'h12_3456_7000, 10);
      run_case("R3 speed up", 32'h4000_0000, 40'h00_0000_0000, 10);
      run_case("R3 slow down", 32'hC000_0000, 40'h00_0000_0000, 10);
      run_case("R3 ppb trim", ppb_trim, 40'h45_0000_0000, 200);
      run_case("R4 wrap", 32'h0000_0000, 40'hFF_FFFF_FFF8, 3);
      t_freeze();
      t_halt();
      t_stage();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule